// File: doc/BRIEF.md
# Time-Slice Task Switcher

This block is a preemptive round-robin scheduler for up to four task slots. Each slot is given a time allotment in ticks of an external prescaled time base. While a task runs, a tick counter measures how much of its allotment it has used. When the allotment runs out, or when the running task raises a yield request, the block picks the next slot that holds a real task. A slot with an allotment of zero is empty and is never run.

Each task change is a fixed three-cycle handshake. The first cycle carries a save pulse with the index of the outgoing task. The second carries a restore pulse with the index of the incoming task. The third raises a completion pulse. An external context store uses the first two pulses to swap register state. The tick counter is frozen for the whole handshake and starts from zero once the incoming task is back in place. The block also presents the running slot's base position in the return stack and a packed information word for that slot.

Top module: `slice_sched`

## Requirements
- R1: During reset no strobe is active and the current slot is 0. After reset the block launches the lowest-numbered slot with a nonzero allotment. It does this with a restore pulse for that slot followed by a completion pulse, and it sends no save pulse.
- R2: The allotment of slot k is bits [6k+5:6k] of `quota_i`, and zero marks an empty slot. The incoming slot is the first slot after the current one, in increasing order and wrapping from 3 to 0, whose allotment is nonzero. If the current slot is the only nonempty one, it is selected again.
- R3: While a task runs, the switch begins on the Q-th tick counted in that slice, where Q is the task's allotment. No save pulse occurs before that tick, whatever the spacing between ticks.
- R4: A yield request sampled while a task runs starts a switch in the next cycle, whatever the tick count.
- R5: A yield request sampled during a switch, or before the first task has launched, has no effect.
- R6: A switch produces a save pulse carrying the outgoing index, then a restore pulse carrying the incoming index in the next cycle, then a completion pulse in the cycle after that. Each pulse lasts one cycle.
- R7: `stack_base_o` is 1 for slot 0 and 8·k for slot k ≥ 1, and it follows the current slot.
- R8: `task_info_o` equals allotment·4 + slot index. Bits [1:0] hold the slot index and bits [7:2] hold the allotment.
- R9: While every allotment is zero after reset, the block stays idle and issues no strobe. It launches as soon as one allotment becomes nonzero.
- R10: The tick count restarts at zero for every slice, so a task resumed after a yield gets its full allotment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quota_i | input | 24 | Four 6-bit allotments, slot k at bits [6k+5:6k] |
| tick_i | input | 1 | One-cycle time-base tick |
| yield_i | input | 1 | Request from the running task to give up the rest of its slice |
| cur_task_o | output | 2 | Index of the current slot |
| save_o | output | 1 | Save pulse for the outgoing context |
| save_idx_o | output | 2 | Outgoing slot index, valid with `save_o` |
| restore_o | output | 1 | Restore pulse for the incoming context |
| restore_idx_o | output | 2 | Incoming slot index, valid with `restore_o` |
| done_o | output | 1 | Completion pulse closing a switch or launch |
| stack_base_o | output | 5 | Return-stack base position of the current slot |
| task_info_o | output | 8 | Packed allotment and slot index of the current slot |

## Verification
The embedded assertions check on every cycle:
- the save, restore and completion ordering and their mutual exclusion;
- that each restore names a nonempty slot;
- that a save follows only a yield or an expiry seen while running;
- that the current slot is held while running;
- that the tick count stays below the allotment and starts each slice at zero.

Only the directed scenarios can show the following:
- the exact tick on which a slice ends when ticks are spaced;
- the skipping of empty slots and the wrap order;
- that a repeated yield during a switch is lost;
- the idle hold with every allotment at zero;
- the stack base and information word values.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [2:0] {
    ST_LAUNCH,
    ST_RUN,
    ST_SAVE,
    ST_RESTORE,
    ST_DONE
  } sched_state_e;
endpackage

// File: rtl/slot_picker.sv
module slot_picker #(
  parameter int NTASK = 4,
  localparam int IDXW = $clog2(NTASK)
) (
  input  logic [NTASK-1:0] valid_i,
  input  logic [IDXW-1:0]  cur_i,
  output logic [IDXW-1:0]  first_o,
  output logic [IDXW-1:0]  next_o,
  output logic             any_o
);
  // Lowest-numbered nonempty slot.
  function automatic logic [IDXW-1:0] lowest_valid(input logic [NTASK-1:0] v);
    logic [IDXW-1:0] r;
    logic found;
    r = '0;
    found = 1'b0;
    for (int k = 0; k < NTASK; k++) begin
      if (!found && v[k]) begin
        r = IDXW'(k);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  // First nonempty slot after c, wrapping; c itself is tried last.
  function automatic logic [IDXW-1:0] after_valid(input logic [NTASK-1:0] v,
                                                  input logic [IDXW-1:0] c);
    logic [IDXW-1:0] r;
    logic found;
    int s;
    r = c;
    found = 1'b0;
    for (int k = 1; k <= NTASK; k++) begin
      s = (int'(c) + k) % NTASK;
      if (!found && v[s]) begin
        r = IDXW'(s);
        found = 1'b1;
      end
    end
    return r;
  endfunction

  assign first_o = lowest_valid(valid_i);
  assign next_o  = after_valid(valid_i, cur_i);
  assign any_o   = |valid_i;
endmodule

// File: rtl/slice_timer.sv
module slice_timer #(
  parameter int QW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_i,
  input  logic          tick_i,
  input  logic [QW-1:0] quota_i,
  output logic          expire_o,
  output logic [QW-1:0] count_o
);
  logic [QW-1:0] cnt_q;
  logic [QW:0]   cnt_inc;

  assign cnt_inc  = {1'b0, cnt_q} + (QW+1)'(1);
  assign expire_o = run_i && tick_i && (cnt_inc >= {1'b0, quota_i});
  assign count_o  = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (expire_o)      cnt_q <= '0;
    else if (tick_i)        cnt_q <= cnt_inc[QW-1:0];
  end

  // R3: the count never reaches the allotment while a task runs
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && quota_i != '0) |-> (cnt_q < quota_i));

  // R10: each slice starts counting from zero
  assert_count_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_i) |-> (cnt_q == '0));
endmodule

// File: rtl/slice_sched.sv
module slice_sched
  import sched_pkg::*;
#(
  parameter int NTASK = 4,
  parameter int QW    = 6,
  parameter int SPW   = 5,
  parameter int SEG   = 8,
  localparam int IDXW  = $clog2(NTASK),
  localparam int INFOW = QW + IDXW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NTASK*QW-1:0] quota_i,
  input  logic                tick_i,
  input  logic                yield_i,
  output logic [IDXW-1:0]     cur_task_o,
  output logic                save_o,
  output logic [IDXW-1:0]     save_idx_o,
  output logic                restore_o,
  output logic [IDXW-1:0]     restore_idx_o,
  output logic                done_o,
  output logic [SPW-1:0]      stack_base_o,
  output logic [INFOW-1:0]    task_info_o
);
  // Return-stack base of a slot: slot 0 skips the reserved entry.
  function automatic logic [SPW-1:0] base_of(input logic [IDXW-1:0] idx);
    if (idx == '0) return SPW'(1);
    return SPW'(int'(idx) * SEG);
  endfunction

  sched_state_e    state_q;
  logic [IDXW-1:0] cur_q;
  logic [QW-1:0]   quota_arr [NTASK];
  logic [NTASK-1:0] valid;
  logic [QW-1:0]   cur_quota;
  logic [IDXW-1:0] first_idx, next_idx;
  logic            any_valid;
  logic            running, expire, switch_req;
  logic [QW-1:0]   slice_count;

  for (genvar g = 0; g < NTASK; g++) begin : g_slot
    assign quota_arr[g] = quota_i[g*QW +: QW];
    assign valid[g]     = (quota_i[g*QW +: QW] != '0);
  end

  assign cur_quota  = quota_arr[cur_q];
  assign running    = (state_q == ST_RUN);
  assign switch_req = running && (yield_i || expire);

  slot_picker #(.NTASK(NTASK)) u_picker (
    .valid_i (valid),
    .cur_i   (cur_q),
    .first_o (first_idx),
    .next_o  (next_idx),
    .any_o   (any_valid)
  );

  slice_timer #(.QW(QW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    (running),
    .tick_i   (tick_i),
    .quota_i  (cur_quota),
    .expire_o (expire),
    .count_o  (slice_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_LAUNCH;
      cur_q   <= '0;
    end else begin
      case (state_q)
        ST_LAUNCH: if (any_valid) begin
          cur_q   <= first_idx;
          state_q <= ST_RESTORE;
        end
        ST_RUN:     if (switch_req) state_q <= ST_SAVE;
        ST_SAVE: begin
          cur_q   <= next_idx;
          state_q <= ST_RESTORE;
        end
        ST_RESTORE: state_q <= ST_DONE;
        ST_DONE:    state_q <= ST_RUN;
        default:    state_q <= ST_LAUNCH;
      endcase
    end
  end

  assign cur_task_o    = cur_q;
  assign save_o        = (state_q == ST_SAVE);
  assign save_idx_o    = cur_q;
  assign restore_o     = (state_q == ST_RESTORE);
  assign restore_idx_o = cur_q;
  assign done_o        = (state_q == ST_DONE);
  assign stack_base_o  = base_of(cur_q);
  assign task_info_o   = {cur_quota, cur_q};

  // R6: strobe ordering and exclusion
  assert_save_then_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
    save_o |=> (restore_o && !save_o));
  assert_restore_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |=> done_o);
  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({save_o, restore_o, done_o}));

  // R2: only nonempty slots are restored; a lone slot is reselected
  assert_restore_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
    restore_o |-> valid[restore_idx_o]);
  assert_lone_reselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (save_o && $countones(valid) == 1) |=> (restore_idx_o == $past(save_idx_o)));

  // R4: a save always follows a yield or expiry seen while running
  assert_save_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(save_o) |-> $past(switch_req));

  // R5: outside the running state nothing can start a save
  assert_yield_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!running) |=> !save_o);

  // R3: the current slot is held while a task runs
  assert_cur_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !switch_req) |=> $stable(cur_task_o));
endmodule

// File: tb/slice_sched_bench.sv
`timescale 1ns/1ps
module slice_sched_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] quota_i = '0;
  logic        tick_i = 1'b0;
  logic        yield_i = 1'b0;
  logic [1:0]  cur_task_o, save_idx_o, restore_idx_o;
  logic        save_o, restore_o, done_o;
  logic [4:0]  stack_base_o;
  logic [7:0]  task_info_o;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  slice_sched u_slice_sched (
    .clk(clk), .rst_n(rst_n), .quota_i(quota_i), .tick_i(tick_i), .yield_i(yield_i),
    .cur_task_o(cur_task_o), .save_o(save_o), .save_idx_o(save_idx_o),
    .restore_o(restore_o), .restore_idx_o(restore_idx_o), .done_o(done_o),
    .stack_base_o(stack_base_o), .task_info_o(task_info_o)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pack(int q0, int q1, int q2, int q3);
    return {6'(q3), 6'(q2), 6'(q1), 6'(q0)};
  endfunction

  task automatic do_reset(logic [23:0] q);
    @(negedge clk);
    rst_n = 1'b0; quota_i = q; tick_i = 1'b0; yield_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset save", int'(save_o), 0);
    chk("R1 reset restore", int'(restore_o), 0);
    chk("R1 reset cur", int'(cur_task_o), 0);
    rst_n = 1'b1;
  endtask

  task automatic check_running(int idx, int q);
    chk("R2 current slot", int'(cur_task_o), idx);
    chk("R7 stack base", int'(stack_base_o), (idx == 0) ? 1 : 8 * idx);
    chk("R8 task info", int'(task_info_o), q * 4 + idx);
    chk("R6 done width", int'(done_o), 0);
  endtask

  task automatic expect_launch(int idx, int q);
    @(negedge clk);
    chk("R1 launch restore", int'(restore_o), 1);
    chk("R1 launch index", int'(restore_idx_o), idx);
    chk("R1 launch no save", int'(save_o), 0);
    @(negedge clk);
    chk("R6 launch done", int'(done_o), 1);
    @(negedge clk);
    check_running(idx, q);
  endtask

  // Entered at the negedge where save_o should be high.
  task automatic expect_switch(int out_idx, int in_idx, int qin);
    chk("R6 save pulse", int'(save_o), 1);
    chk("R6 save index", int'(save_idx_o), out_idx);
    @(negedge clk);
    chk("R6 restore pulse", int'(restore_o), 1);
    chk("R2 restore index", int'(restore_idx_o), in_idx);
    chk("R6 save dropped", int'(save_o), 0);
    @(negedge clk);
    chk("R6 done pulse", int'(done_o), 1);
    chk("R6 restore dropped", int'(restore_o), 0);
    @(negedge clk);
    check_running(in_idx, qin);
  endtask

  // Give n ticks with gap idle cycles between them; the save is due on the n-th.
  task automatic tick_slice(int n, int gap, int out_idx);
    for (int i = 1; i <= n; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      if (i < n) begin
        chk("R3 no early save", int'(save_o), 0);
        for (int j = 0; j < gap; j++) begin
          @(negedge clk);
          chk("R3 idle gap no save", int'(save_o), 0);
        end
      end else begin
        chk("R3 save on last tick", int'(save_o), 1);
        chk("R3 save index", int'(save_idx_o), out_idx);
      end
    end
  endtask

  task automatic test_idle_start();
    do_reset(pack(0, 0, 0, 0));
    for (int i = 0; i < 5; i++) begin
      tick_i = 1'b1; yield_i = i[0];
      @(negedge clk);
      chk("R9 idle no save", int'(save_o), 0);
      chk("R9 idle no restore", int'(restore_o), 0);
      chk("R5 early yield ignored", int'(done_o), 0);
    end
    tick_i = 1'b0; yield_i = 1'b0;
    quota_i = pack(0, 3, 0, 2);
    expect_launch(1, 3);
  endtask

  task automatic test_expiry_skip();
    tick_slice(3, 0, 1);
    expect_switch(1, 3, 2);
    tick_slice(2, 1, 3);
    expect_switch(3, 1, 3);
  endtask

  task automatic test_yield();
    do_reset(pack(5, 5, 5, 5));
    expect_launch(0, 5);
    for (int i = 0; i < 2; i++) begin
      tick_i = 1'b1;
      @(negedge clk);
      tick_i = 1'b0;
      chk("R3 partial slice", int'(save_o), 0);
    end
    yield_i = 1'b1;
    @(negedge clk);
    chk("R4 yield save", int'(save_o), 1);
    chk("R4 yield index", int'(save_idx_o), 0);
    @(negedge clk);
    chk("R5 restore despite yield", int'(restore_o), 1);
    chk("R2 yield next slot", int'(restore_idx_o), 1);
    @(negedge clk);
    chk("R5 done despite yield", int'(done_o), 1);
    yield_i = 1'b0;
    @(negedge clk);
    check_running(1, 5);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R5 held yield lost", int'(save_o), 0);
    end
    tick_slice(5, 0, 1);
    @(negedge clk);
    chk("R10 full slice restore", int'(restore_idx_o), 2);
    @(negedge clk);
    @(negedge clk);
    check_running(2, 5);
  endtask

  task automatic test_single();
    do_reset(pack(0, 0, 4, 0));
    expect_launch(2, 4);
    yield_i = 1'b1;
    @(negedge clk);
    yield_i = 1'b0;
    expect_switch(2, 2, 4);
    tick_slice(4, 2, 2);
    expect_switch(2, 2, 4);
  endtask

  initial begin
    test_idle_start();
    test_expiry_skip();
    test_yield();
    test_single();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule